// File: doc/BRIEF.md
# Smart-Card ETU Time-Out Counter Bank

This block is a bank of three 8-bit down-counters that advance on an elementary-time-unit (ETU) tick. A mode byte written into a configuration slot arranges them in one of several ways. All counters can be stopped. Counters 3 and 2 can form a one-shot 16-bit counter, optionally beside an 8-bit auto-reload counter built from counter 1. All three can also form one 24-bit counter. Some arrangements start counting when the mode byte is written. Others wait for a start-bit pulse seen on the card I/O line.

When a count ends, a sticky status flag is set and the interrupt line goes high. Software clears both flags by reading status. A companion block supplies the one-clock ETU tick and the start-bit pulse.

Top module: `etu_tmo_bank`

## Requirements
- R1: After reset both flags and the interrupt are low, the mode readback is 0x00 and all three reload slots hold zero.
- R2: Register slots are chosen by wr_addr: 0 is reload 1, 1 is reload 2, 2 is reload 3 and 3 is the mode byte. In mode 0x61 the 16-bit value {reload3, reload2} is loaded when the mode byte is written. flag_c3 is set on the tick that completes that many ETU ticks. Counter 1 stays idle and never sets flag_c1, including after start bits.
- R3: In modes 0x65 and 0xE5 the 16-bit counter behaves as in R2. Counter 1 ignores ticks until the first start bit after the mode write, and that start bit loads reload1. From then on flag_c1 is set every reload1 ticks, and counter 1 reloads itself each time.
- R4: In mode 0xE5, counter 1 stops after the 12th tick that follows its start bit, and it sets no further flag_c1.
- R5: In mode 0x68, the 24-bit value {reload3, reload2, reload1} is loaded on the mode write. flag_c3 (not flag_c1) is set on the tick that completes that many ticks.
- R6: In mode 0x7C, every start bit reloads the 24-bit counter from the reload slots and runs it, including a start bit that arrives while a count is running. Writing a reload slot during a count does not change that count. The end of the count sets flag_c3.
- R7: Writing 0x00, or any code not listed above, stops every counter, and no flag is set afterwards.
- R8: A flag stays set until a status read (stat_rd). The read clears both flags. A terminal count in the same cycle as a read leaves its flag set.
- R9: irq is high exactly while either flag is set.
- R10: Counters change only on cycles with etu_tick high. A zero load value ends on the first tick.
- R11: mode_rd returns the last byte written to the mode slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register slot select |
| wr_data | input | 8 | Register write data |
| stat_rd | input | 1 | Status read pulse, clears flags |
| etu_tick | input | 1 | One-clock ETU tick |
| start_bit | input | 1 | One-clock start-bit detect pulse |
| mode_rd | output | 8 | Mode byte readback |
| flag_c1 | output | 1 | Counter 1 terminal-count flag |
| flag_c3 | output | 1 | 16/24-bit terminal-count flag |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: a terminal count that sets a flag, and a status read that clears it. The bench arms a 16-bit count of two ticks. It then drives the second tick together with stat_rd. It expects flag_c3 and irq to stay high afterwards, and a later lone read to clear them. A checker property also requires that a read with no terminal event in the same cycle leaves both flags low.

// File: rtl/etu_tmo_pkg.sv
package etu_tmo_pkg;

  typedef enum logic [2:0] {
    CFG_OFF,
    CFG_H16,
    CFG_H16_L8,
    CFG_H16_L8G,
    CFG_F24,
    CFG_F24S
  } cfg_t;

  localparam logic [7:0] CODE_STOP    = 8'h00;
  localparam logic [7:0] CODE_H16     = 8'h61;
  localparam logic [7:0] CODE_H16_L8  = 8'h65;
  localparam logic [7:0] CODE_F24     = 8'h68;
  localparam logic [7:0] CODE_F24S    = 8'h7C;
  localparam logic [7:0] CODE_H16_L8G = 8'hE5;

  // map a written mode byte to an arrangement; unknown bytes stop
  function automatic cfg_t decode_mode(input logic [7:0] code);
    case (code)
      CODE_H16:     return CFG_H16;
      CODE_H16_L8:  return CFG_H16_L8;
      CODE_H16_L8G: return CFG_H16_L8G;
      CODE_F24:     return CFG_F24;
      CODE_F24S:    return CFG_F24S;
      default:      return CFG_OFF;
    endcase
  endfunction

  // the tick that finds this value ends the count (zero ends at once)
  function automatic logic at_last(input logic [63:0] v);
    return v <= 64'd1;
  endfunction

  function automatic logic is_chain(input cfg_t c);
    return (c == CFG_F24) || (c == CFG_F24S);
  endfunction

  function automatic logic uses_lo(input cfg_t c);
    return (c == CFG_H16_L8) || (c == CFG_H16_L8G);
  endfunction

endpackage

// File: rtl/etu_tmo_regs.sv
module etu_tmo_regs #(
  parameter int W  = 8,
  parameter int N  = 3,
  parameter int AW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] rl_all,
  output logic [7:0]     mode_q,
  output logic           mode_wr
);
  localparam logic [AW-1:0] MODE_ADDR = AW'(N);

  for (genvar i = 0; i < N; i++) begin : g_rl
    logic [W-1:0] rl_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        rl_q <= '0;
      else if (wr_en && wr_addr == AW'(i))
        rl_q <= wr_data;
    end
    assign rl_all[i*W +: W] = rl_q;
  end

  assign mode_wr = wr_en && (wr_addr == MODE_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= '0;
    else if (mode_wr)
      mode_q <= 8'(wr_data);
  end
endmodule

// File: rtl/etu_tmo_count.sv
module etu_tmo_count
  import etu_tmo_pkg::*;
#(
  parameter int W         = 8,
  parameter int GUARD_ETU = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  logic [7:0]   mode_code,
  input  logic [3*W-1:0] rl_all,
  input  logic         tick,
  input  logic         sbit,
  output logic         evt_lo,
  output logic         evt_hi
);
  localparam int FW = 3 * W;
  localparam int GW = $clog2(GUARD_ETU + 1);

  cfg_t          cfg_q;
  logic [2*W-1:0] hi_q;
  logic [W-1:0]   lo_q;
  logic          hi_run, lo_run, lo_arm;
  logic [GW-1:0] guard_q;

  cfg_t         cfg_new;
  logic         chain, s_load24, s_load8, hi_step, lo_step, guard_end;
  logic [FW-1:0] full;

  assign cfg_new  = decode_mode(mode_code);
  assign chain    = is_chain(cfg_q);
  assign full     = {hi_q, lo_q};
  assign s_load24 = (cfg_q == CFG_F24S) && sbit && !mode_wr;
  assign s_load8  = !chain && lo_arm && sbit && !mode_wr;
  assign hi_step  = tick && hi_run && !s_load24 && !mode_wr;
  assign lo_step  = tick && lo_run && !mode_wr;
  assign evt_hi   = hi_step && (chain ? at_last(64'(full)) : at_last(64'(hi_q)));
  assign evt_lo   = lo_step && at_last(64'(lo_q));
  assign guard_end = (cfg_q == CFG_H16_L8G) && lo_step &&
                     (guard_q == GW'(GUARD_ETU - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CFG_OFF;
      hi_q    <= '0;
      lo_q    <= '0;
      hi_run  <= 1'b0;
      lo_run  <= 1'b0;
      lo_arm  <= 1'b0;
      guard_q <= '0;
    end else if (mode_wr) begin
      cfg_q   <= cfg_new;
      lo_run  <= 1'b0;
      guard_q <= '0;
      lo_arm  <= uses_lo(cfg_new);
      hi_run  <= (cfg_new == CFG_H16) || uses_lo(cfg_new) || (cfg_new == CFG_F24);
      if (cfg_new == CFG_F24) begin
        {hi_q, lo_q} <= rl_all;
      end else begin
        hi_q <= rl_all[FW-1:W];
        lo_q <= '0;
      end
    end else if (chain) begin
      if (s_load24) begin
        {hi_q, lo_q} <= rl_all;
        hi_run       <= 1'b1;
      end else if (hi_step) begin
        {hi_q, lo_q} <= evt_hi ? '0 : full - FW'(1);
        if (evt_hi) hi_run <= 1'b0;
      end
    end else begin
      if (hi_step) begin
        hi_q <= evt_hi ? '0 : hi_q - 1'b1;
        if (evt_hi) hi_run <= 1'b0;
      end
      if (s_load8) begin
        lo_q    <= rl_all[W-1:0];
        lo_run  <= 1'b1;
        lo_arm  <= 1'b0;
        guard_q <= '0;
      end else if (lo_step) begin
        lo_q    <= evt_lo ? rl_all[W-1:0] : lo_q - 1'b1;
        guard_q <= guard_q + 1'b1;
        if (guard_end) lo_run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/etu_tmo_flags.sv
module etu_tmo_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lo,
  input  logic set_hi,
  input  logic clr,
  output logic to_lo,
  output logic to_hi
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_lo <= 1'b0;
      to_hi <= 1'b0;
    end else begin
      to_lo <= (to_lo && !clr) || set_lo;
      to_hi <= (to_hi && !clr) || set_hi;
    end
  end
endmodule

// File: rtl/etu_tmo_bank.sv
module etu_tmo_bank #(
  parameter int CNT_W     = 8,
  parameter int GUARD_ETU = 12,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              stat_rd,
  input  logic              etu_tick,
  input  logic              start_bit,
  output logic [7:0]        mode_rd,
  output logic              flag_c1,
  output logic              flag_c3,
  output logic              irq
);
  localparam int NCNT = 3;

  logic [NCNT*CNT_W-1:0] rl_all;
  logic                  mode_wr;
  logic                  evt_lo_tc, evt_hi_tc;

  etu_tmo_regs #(.W(CNT_W), .N(NCNT), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rl_all(rl_all), .mode_q(mode_rd), .mode_wr(mode_wr)
  );

  etu_tmo_count #(.W(CNT_W), .GUARD_ETU(GUARD_ETU)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(8'(wr_data)),
    .rl_all(rl_all), .tick(etu_tick), .sbit(start_bit),
    .evt_lo(evt_lo_tc), .evt_hi(evt_hi_tc)
  );

  etu_tmo_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_lo(evt_lo_tc), .set_hi(evt_hi_tc),
    .clr(stat_rd), .to_lo(flag_c1), .to_hi(flag_c3)
  );

  assign irq = flag_c1 | flag_c3;
endmodule

module etu_tmo_bank_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic [DW-1:0] wr_data,
  input logic          stat_rd,
  input logic          evt_lo,
  input logic          evt_hi,
  input logic          flag_c1,
  input logic          flag_c3,
  input logic          irq
);
  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wr_data == '0) |=> (!evt_lo && !evt_hi));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_c1 && !stat_rd) |=> flag_c1);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !evt_lo && !evt_hi) |=> (!flag_c1 && !flag_c3));

  // R3
  lo_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lo |=> flag_c1);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_lo || evt_hi));
endmodule

bind etu_tmo_bank etu_tmo_bank_chk #(.DW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .wr_data(wr_data),
  .stat_rd(stat_rd), .evt_lo(evt_lo_tc), .evt_hi(evt_hi_tc),
  .flag_c1(flag_c1), .flag_c3(flag_c3), .irq(irq)
);

// File: tb/etu_tmo_bank_bench.sv
`timescale 1ns/1ps
module etu_tmo_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       stat_rd = 1'b0;
  logic       etu_tick = 1'b0;
  logic       start_bit = 1'b0;
  logic [7:0] mode_rd;
  logic       flag_c1, flag_c3, irq;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  etu_tmo_bank u_etu_tmo_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat_rd(stat_rd), .etu_tick(etu_tick),
    .start_bit(start_bit), .mode_rd(mode_rd), .flag_c1(flag_c1),
    .flag_c3(flag_c3), .irq(irq)
  );

  typedef struct {
    string      tag;
    logic       e1;
    logic       e3;
    bit         cm;
    logic [7:0] em;
  } exp_t;
  exp_t sb_q[$];

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      tests++;
      if (flag_c1 !== e.e1 || flag_c3 !== e.e3 || irq !== (e.e1 | e.e3)) begin
        fails++;
        $display("FAIL %s: c1/c3/irq=%b%b%b expected %b%b%b",
                 e.tag, flag_c1, flag_c3, irq, e.e1, e.e3, e.e1 | e.e3);
      end
      if (e.cm && mode_rd !== e.em) begin
        fails++;
        $display("FAIL %s: mode_rd=%h expected %h", e.tag, mode_rd, e.em);
      end
    end
  end

  task automatic expect_fl(string tag, logic e1, logic e3,
                           bit cm = 1'b0, logic [7:0] em = 8'h00);
    sb_q.push_back('{tag, e1, e3, cm, em});
    @(negedge clk); #1;
  endtask

  task automatic step(bit t, bit s, bit r);
    etu_tick = t; start_bit = s; stat_rd = r;
    @(posedge clk); #1;
    etu_tick = 0; start_bit = 0; stat_rd = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_fl("R1 reset flags/mode", 0, 0, 1, 8'h00);
    // R1/R10 reload slots are zero after reset: first tick ends the count
    wr(2'd3, 8'h61);
    ticks(1);
    expect_fl("R1 R10 zero reload ends on first tick", 0, 1);
    step(0, 0, 1);
    expect_fl("R8 read clears", 0, 0);

    // R2 16-bit count of 5, R10 idle cycles hold, R11 readback
    wr(2'd1, 8'd5); wr(2'd2, 8'd0); wr(2'd3, 8'h61);
    expect_fl("R11 mode readback 61", 0, 0, 1, 8'h61);
    repeat (3) step(0, 0, 0);
    ticks(4);
    expect_fl("R10 R2 no end before 5th tick", 0, 0);
    ticks(1);
    expect_fl("R2 end after 5 ticks", 0, 1);
    step(0, 1, 0);
    ticks(5);
    expect_fl("R2 counter1 idle", 0, 1);
    step(0, 0, 1);

    // R2 high byte carries: 256 ticks
    wr(2'd1, 8'd0); wr(2'd2, 8'd1); wr(2'd3, 8'h61);
    ticks(255);
    expect_fl("R2 256 count not yet", 0, 0);
    ticks(1);
    expect_fl("R2 256 count ends", 0, 1);
    step(0, 0, 1);

    // R3 auto-reload counter 1 beside 16-bit
    wr(2'd0, 8'd3); wr(2'd1, 8'd10); wr(2'd2, 8'd0); wr(2'd3, 8'h65);
    ticks(2);
    expect_fl("R3 counter1 waits for start bit", 0, 0);
    step(0, 1, 0);
    ticks(3);
    expect_fl("R3 first reload period", 1, 0);
    step(0, 0, 1);
    ticks(3);
    expect_fl("R3 second reload period", 1, 0);
    step(0, 0, 1);
    ticks(2);
    expect_fl("R3 16-bit ends at tick 10", 0, 1);
    ticks(1);
    expect_fl("R3 third reload period", 1, 1);
    step(0, 0, 1);

    // R8 terminal count in same cycle as read
    wr(2'd1, 8'd2); wr(2'd2, 8'd0); wr(2'd3, 8'h61);
    ticks(1);
    step(1, 0, 1);
    expect_fl("R8 set beats clear", 0, 1);
    step(0, 0, 1);
    expect_fl("R8 R9 cleared by read", 0, 0);

    // R4 guard stop after 12 ticks
    wr(2'd0, 8'd5); wr(2'd1, 8'hFF); wr(2'd2, 8'd0); wr(2'd3, 8'hE5);
    step(0, 1, 0);
    ticks(5);
    expect_fl("R4 first period", 1, 0);
    step(0, 0, 1);
    ticks(5);
    expect_fl("R4 second period", 1, 0);
    step(0, 0, 1);
    ticks(10);
    expect_fl("R4 counter1 halted after 12th tick", 0, 0);

    // R7 stop code and unknown code
    wr(2'd3, 8'h00);
    ticks(300);
    expect_fl("R7 stop halts 16-bit", 0, 0, 1, 8'h00);
    wr(2'd1, 8'd1); wr(2'd2, 8'd0); wr(2'd3, 8'h42);
    step(0, 1, 0);
    ticks(3);
    expect_fl("R7 unknown code stopped", 0, 0, 1, 8'h42);

    // R5 24-bit chain of 260
    wr(2'd0, 8'd4); wr(2'd1, 8'd1); wr(2'd2, 8'd0); wr(2'd3, 8'h68);
    step(0, 1, 0);
    ticks(259);
    expect_fl("R5 24-bit not yet", 0, 0);
    ticks(1);
    expect_fl("R5 24-bit ends, c3 only", 0, 1);
    step(0, 0, 1);

    // R6 start-bit triggered 24-bit
    wr(2'd0, 8'd6); wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd3, 8'h7C);
    ticks(3);
    expect_fl("R6 waits for start bit", 0, 0);
    step(0, 1, 0);
    ticks(5);
    expect_fl("R6 running", 0, 0);
    wr(2'd0, 8'd2);
    ticks(1);
    expect_fl("R6 mid-count write ignored", 0, 1);
    step(0, 0, 1);
    step(0, 1, 0);
    ticks(1);
    expect_fl("R6 new value pending", 0, 0);
    step(0, 1, 0);
    ticks(1);
    expect_fl("R6 restart on start bit", 0, 0);
    ticks(1);
    expect_fl("R6 new value used", 0, 1);

    summary();
  end
endmodule